// File: doc/BRIEF.md
# Qualified Hysteresis Trigger Detector

The block watches a stream of 8-bit samples and emits a single-cycle trigger pulse when a programmed condition is met. The sample is taken from one of four 16-bit channels, using either the upper or the lower byte. Four families of condition are available:

- a Schmitt-style level crossing whose low and high states only count after a minimum dwell,
- a glitch (a pulse past the opposite level that is shorter than its dwell limit),
- a masked digital pattern that either begins or stops matching,
- an edge on an asynchronous external input.

Triggering is one-shot. A write of 1 to the arm control clears the detector history and starts a search. A write of 0 abandons the search. Once a trigger fires, the detector stays idle until software arms it again. Two status bits report whether a search is in progress and whether a trigger has been captured since the last arm.

Top module: `trig_qualifier`

## Requirements
- R1: `srcSel` values 0..3 take bits [15:8] of channel 0..3, and values 4..7 take bits [7:0] of channel 0..3. Channel n occupies `chanData[16n+15:16n]`.
- R2: Type 2 (level rising) fires on the first enabled sample that is at or above `highLevel` and whose run of consecutive such samples reaches `highTime`, provided a low state was qualified before it. `trigPulse` is high for exactly the one cycle after that sample's clock edge.
- R3: A low state is qualified only by `lowTime` consecutive enabled samples at or below `lowLevel`. Any other sample breaks the run. A dwell time of 0 behaves like 1.
- R4: Type 3 (level falling) fires on the sample that completes a qualified low run after a qualified high state.
- R5: Type 4 fires on the first sample at or below `lowLevel` after a qualified low state, when samples at or above `highLevel` occurred in between without qualifying high. Type 5 is the mirror image, using the high state and a short low excursion.
- R6: For types 6 and 7, a sample matches when `(sample ^ highLevel) & lowLevel` is zero. Type 6 fires when the sample goes from not matching to matching, and type 7 fires when it goes from matching to not matching. The first enabled sample after arming only sets the reference.
- R7: Types 0 and 1 fire on a rising or falling edge of `extIn`, passed through a two-flop synchroniser. The pulse appears after the third clock edge following the input change. `sampleEn` does not gate these types.
- R8: Writing `armVal`=1 with `armWr` starts one search. After a trigger fires, or after a write of 0, no pulse occurs until the next arm.
- R9: `status[0]` (busy) is 1 from an arm until a fire or a stop. `status[1]` (recording) is set by a fire and cleared by any arm write.
- R10: After reset, `trigPulse` is 0 and `status` is 0.
- R11: Samples presented with `sampleEn` low neither count toward nor break any run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rstN | input | 1 | active-low synchronous reset |
| armWr | input | 1 | arm control write strobe |
| armVal | input | 1 | 1 to arm, 0 to stop |
| sampleEn | input | 1 | sample valid this cycle |
| chanData | input | 64 | four 16-bit channel samples |
| srcSel | input | 3 | trigger source byte select |
| trigType | input | 3 | trigger condition code |
| lowLevel | input | 8 | low reference level, or digital mask |
| highLevel | input | 8 | high reference level, or digital pattern |
| lowTime | input | 8 | low dwell time in samples |
| highTime | input | 8 | high dwell time in samples |
| extIn | input | 1 | asynchronous external trigger |
| trigPulse | output | 1 | one-cycle trigger pulse |
| status | output | 2 | {recording, busy} |

## Verification
The glitch conditions are the hardest to reach from the ports. They need a qualified state first, then an excursion that touches the opposite level without completing its dwell, and then a return. A plain stimulus stream almost never produces this sequence. The bench therefore writes exact sample sequences for each case. One case uses an excursion one sample short of the dwell limit, so the glitch fires. The other uses an excursion that just reaches the limit, so it qualifies as a level and the glitch must not fire. Every sample sequence places the inverted sample in the unselected bytes, so any mistake in byte selection changes the result.

// File: rtl/trig_pkg.sv
package trig_pkg;
  typedef enum logic [2:0] {
    T_EXT_RISE  = 3'd0,
    T_EXT_FALL  = 3'd1,
    T_LVL_RISE  = 3'd2,
    T_LVL_FALL  = 3'd3,
    T_GLT_RISE  = 3'd4,
    T_GLT_FALL  = 3'd5,
    T_PAT_ENTER = 3'd6,
    T_PAT_EXIT  = 3'd7
  } trig_type_e;

  typedef enum logic [1:0] {
    Q_NONE = 2'd0,
    Q_LOW  = 2'd1,
    Q_HIGH = 2'd2
  } qual_e;

  typedef struct packed {
    logic clear;   // wipe detector history (arm)
    logic search;  // a search is active
  } ctl_strobe_t;
endpackage

// File: rtl/trig_datapath.sv
module trig_datapath
  import trig_pkg::*;
#(
  parameter int CH_NUM = 4,
  parameter int TIME_W = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  ctl_strobe_t           ctl,
  input  logic                  sampleEn,
  input  logic [CH_NUM*16-1:0]  chanData,
  input  logic [$clog2(CH_NUM):0] srcSel,
  input  logic [2:0]            trigType,
  input  logic [7:0]            lowLevel,
  input  logic [7:0]            highLevel,
  input  logic [TIME_W-1:0]     lowTime,
  input  logic [TIME_W-1:0]     highTime,
  input  logic                  extIn,
  output logic                  condHit
);
  localparam int SEL_W = $clog2(CH_NUM);
  localparam logic [TIME_W-1:0] RUN_MAX = '1;

  // source byte selection
  logic [7:0] upperB [CH_NUM];
  logic [7:0] lowerB [CH_NUM];
  for (genvar ch = 0; ch < CH_NUM; ch++) begin : g_split
    assign upperB[ch] = chanData[ch*16+8 +: 8];
    assign lowerB[ch] = chanData[ch*16   +: 8];
  end

  logic [7:0] selByte;
  assign selByte = srcSel[SEL_W] ? lowerB[srcSel[SEL_W-1:0]] : upperB[srcSel[SEL_W-1:0]];

  // level comparators and dwell counters
  logic belowNow, aboveNow;
  assign belowNow = selByte <= lowLevel;
  assign aboveNow = selByte >= highLevel;

  logic [TIME_W-1:0] lowRun, highRun, lowRunNext, highRunNext, needLow, needHigh;
  assign lowRunNext  = (lowRun  == RUN_MAX) ? RUN_MAX : lowRun  + 1'b1;
  assign highRunNext = (highRun == RUN_MAX) ? RUN_MAX : highRun + 1'b1;
  assign needLow  = (lowTime  == '0) ? TIME_W'(1) : lowTime;
  assign needHigh = (highTime == '0) ? TIME_W'(1) : highTime;

  logic lowQualNow, highQualNow;
  assign lowQualNow  = belowNow && (lowRunNext  >= needLow);
  assign highQualNow = aboveNow && (highRunNext >= needHigh);

  qual_e qual;
  logic  highTouched, lowTouched;
  logic  prevMatch, prevValid;
  logic  patMatch;
  assign patMatch = ((selByte ^ highLevel) & lowLevel) == 8'h00;

  always_ff @(posedge clk) begin
    if (!rstN || ctl.clear) begin
      lowRun      <= '0;
      highRun     <= '0;
      qual        <= Q_NONE;
      highTouched <= 1'b0;
      lowTouched  <= 1'b0;
      prevMatch   <= 1'b0;
      prevValid   <= 1'b0;
    end else if (sampleEn) begin
      lowRun  <= belowNow ? lowRunNext  : '0;
      highRun <= aboveNow ? highRunNext : '0;
      if (lowQualNow)       qual <= Q_LOW;
      else if (highQualNow) qual <= Q_HIGH;
      // short excursion past the high level while low is qualified
      if (belowNow || highQualNow)          highTouched <= 1'b0;
      else if (aboveNow && qual == Q_LOW)   highTouched <= 1'b1;
      // short excursion past the low level while high is qualified
      if (aboveNow || lowQualNow)           lowTouched <= 1'b0;
      else if (belowNow && qual == Q_HIGH)  lowTouched <= 1'b1;
      prevMatch <= patMatch;
      prevValid <= 1'b1;
    end
  end

  // external input synchroniser and edge detection
  logic sync0, sync1, sync1Prev;
  always_ff @(posedge clk) begin
    if (!rstN) begin
      sync0     <= 1'b0;
      sync1     <= 1'b0;
      sync1Prev <= 1'b0;
    end else begin
      sync0     <= extIn;
      sync1     <= sync0;
      sync1Prev <= sync1;
    end
  end

  logic extRise, extFall;
  assign extRise = sync1 && !sync1Prev;
  assign extFall = !sync1 && sync1Prev;

  logic sampleHit;
  always_comb begin
    sampleHit = 1'b0;
    case (trig_type_e'(trigType))
      T_LVL_RISE:  sampleHit = highQualNow && qual == Q_LOW;
      T_LVL_FALL:  sampleHit = lowQualNow  && qual == Q_HIGH;
      T_GLT_RISE:  sampleHit = belowNow && qual == Q_LOW  && highTouched;
      T_GLT_FALL:  sampleHit = aboveNow && qual == Q_HIGH && lowTouched;
      T_PAT_ENTER: sampleHit = prevValid &&  patMatch && !prevMatch;
      T_PAT_EXIT:  sampleHit = prevValid && !patMatch &&  prevMatch;
      default:     sampleHit = 1'b0;
    endcase
  end

  always_comb begin
    case (trig_type_e'(trigType))
      T_EXT_RISE: condHit = ctl.search && extRise;
      T_EXT_FALL: condHit = ctl.search && extFall;
      default:    condHit = ctl.search && sampleEn && sampleHit;
    endcase
  end

  // R11: disabled cycles leave the dwell counters alone
  a_r11_hold_runs: assert property (@(posedge clk) disable iff (!rstN)
    (!sampleEn && !ctl.clear) |=> ($stable(lowRun) && $stable(highRun)));

  // R3: a low state is only entered on an enabled below-level sample
  a_r3_low_entry: assert property (@(posedge clk) disable iff (!rstN)
    (qual == Q_LOW && $past(qual) != Q_LOW) |-> $past(belowNow && sampleEn));

  // R7: a synchronised rising edge reflects the pin two clocks earlier
  a_r7_sync_depth: assert property (@(posedge clk) disable iff (!rstN)
    extRise |-> $past(extIn, 2));
endmodule

// File: rtl/trig_control.sv
module trig_control
  import trig_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        armWr,
  input  logic        armVal,
  input  logic        condHit,
  output ctl_strobe_t ctl,
  output logic        trigPulse,
  output logic        busy,
  output logic        recording
);
  assign ctl.clear  = armWr && armVal;
  assign ctl.search = busy && !armWr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy      <= 1'b0;
      recording <= 1'b0;
      trigPulse <= 1'b0;
    end else if (armWr) begin
      busy      <= armVal;
      recording <= 1'b0;
      trigPulse <= 1'b0;
    end else if (busy && condHit) begin
      busy      <= 1'b0;
      recording <= 1'b1;
      trigPulse <= 1'b1;
    end else begin
      trigPulse <= 1'b0;
    end
  end

  a_r2_single_cycle: assert property (@(posedge clk) disable iff (!rstN)
    trigPulse |=> !trigPulse);

  a_r8_fire_ends_search: assert property (@(posedge clk) disable iff (!rstN)
    trigPulse |-> (!busy && $past(busy)));

  a_r9_status_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({busy, recording}));

  a_r9_recording_on_fire: assert property (@(posedge clk) disable iff (!rstN)
    trigPulse |-> recording);
endmodule

// File: rtl/trig_qualifier.sv
module trig_qualifier
  import trig_pkg::*;
#(
  parameter int CH_NUM = 4,
  parameter int TIME_W = 8
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    armWr,
  input  logic                    armVal,
  input  logic                    sampleEn,
  input  logic [CH_NUM*16-1:0]    chanData,
  input  logic [$clog2(CH_NUM):0] srcSel,
  input  logic [2:0]              trigType,
  input  logic [7:0]              lowLevel,
  input  logic [7:0]              highLevel,
  input  logic [TIME_W-1:0]       lowTime,
  input  logic [TIME_W-1:0]       highTime,
  input  logic                    extIn,
  output logic                    trigPulse,
  output logic [1:0]              status
);
  ctl_strobe_t ctl;
  logic condHit, busy, recording;

  trig_datapath #(.CH_NUM(CH_NUM), .TIME_W(TIME_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .sampleEn(sampleEn),
    .chanData(chanData), .srcSel(srcSel), .trigType(trigType),
    .lowLevel(lowLevel), .highLevel(highLevel),
    .lowTime(lowTime), .highTime(highTime), .extIn(extIn),
    .condHit(condHit)
  );

  trig_control u_ctl (
    .clk(clk), .rstN(rstN), .armWr(armWr), .armVal(armVal),
    .condHit(condHit), .ctl(ctl), .trigPulse(trigPulse),
    .busy(busy), .recording(recording)
  );

  assign status = {recording, busy};
endmodule

// File: tb/trig_qualifier_bench.sv
`timescale 1ns/1ps
module trig_qualifier_bench;
  typedef struct packed {
    logic [2:0]  typ;
    logic [2:0]  sel;
    logic [7:0]  lo;
    logic [7:0]  hi;
    logic [7:0]  loT;
    logic [7:0]  hiT;
    logic [63:0] smp;
    logic [3:0]  exp;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{3'd2, 3'd0, 8'h28, 8'hC8, 8'd2, 8'd2, 64'hFAFAFAFAFAFA0A0A, 4'd3},
    '{3'd2, 3'd5, 8'h28, 8'hC8, 8'd3, 8'd2, 64'hFAFAFAFAFAFA0A0A, 4'd15},
    '{3'd2, 3'd6, 8'h28, 8'hC8, 8'd3, 8'd2, 64'hFAFAFAFAFA0A0A0A, 4'd4},
    '{3'd3, 3'd1, 8'h28, 8'hC8, 8'd2, 8'd2, 64'h0A0AFAFA0A0AFAFA, 4'd3},
    '{3'd2, 3'd4, 8'h28, 8'hC8, 8'd2, 8'd2, 64'hFAFAFAFAFA0A640A, 4'd15},
    '{3'd4, 3'd2, 8'h28, 8'hC8, 8'd2, 8'd3, 64'h0A0A0A0AFAFA0A0A, 4'd4},
    '{3'd4, 3'd3, 8'h28, 8'hC8, 8'd2, 8'd3, 64'h0A0A0AFAFAFA0A0A, 4'd15},
    '{3'd5, 3'd0, 8'h28, 8'hC8, 8'd2, 8'd2, 64'hFAFAFAFAFA0AFAFA, 4'd3},
    '{3'd6, 3'd1, 8'hF0, 8'hA0, 8'd0, 8'd0, 64'h00000000A1A71505, 4'd2},
    '{3'd7, 3'd2, 8'hF0, 8'hA0, 8'd0, 8'd0, 64'h000000000030AFA0, 4'd2},
    '{3'd6, 3'd3, 8'hF0, 8'hA0, 8'd0, 8'd0, 64'h000000A000AAA5A3, 4'd4},
    '{3'd2, 3'd7, 8'h28, 8'hC8, 8'd0, 8'd0, 64'hFFFFFFFFFFFFFF00, 4'd1}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic armWr = 1'b0, armVal = 1'b0, sampleEn = 1'b0, extIn = 1'b0;
  logic [63:0] chanData = '0;
  logic [2:0] srcSel = '0, trigType = '0;
  logic [7:0] lowLevel = '0, highLevel = '0, lowTime = '0, highTime = '0;
  logic trigPulse;
  logic [1:0] status;

  int total = 0, bad = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  trig_qualifier u_trig_qualifier (
    .clk(clk), .rstN(rstN), .armWr(armWr), .armVal(armVal),
    .sampleEn(sampleEn), .chanData(chanData), .srcSel(srcSel),
    .trigType(trigType), .lowLevel(lowLevel), .highLevel(highLevel),
    .lowTime(lowTime), .highTime(highTime), .extIn(extIn),
    .trigPulse(trigPulse), .status(status)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // selected byte carries s; every other byte carries ~s
  function automatic logic [63:0] mkChan(input logic [2:0] sel, input logic [7:0] s);
    logic [63:0] d;
    d = {8{~s}};
    if (sel[2]) d[sel[1:0]*16 +: 8]     = s;
    else        d[sel[1:0]*16 + 8 +: 8] = s;
    return d;
  endfunction

  function automatic string tagFor(input logic [2:0] t);
    case (t)
      3'd2:    return "R1 R2 R3";
      3'd3:    return "R1 R4";
      3'd4, 3'd5: return "R1 R5";
      default: return "R1 R6";
    endcase
  endfunction

  task automatic armWrite(input logic v);
    armWr = 1'b1; armVal = v;
    @(posedge clk); @(negedge clk);
    armWr = 1'b0; armVal = 1'b0;
  endtask

  // one sample, then return the pulse seen after that edge
  task automatic feed(input logic [7:0] s, input logic en, output logic p);
    chanData = mkChan(srcSel, s); sampleEn = en;
    @(posedge clk); @(negedge clk);
    p = trigPulse;
    sampleEn = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic p;
    int first, cnt;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk(trigPulse == 1'b0, "R10 pulse", trigPulse, 0);
    chk(status == 2'b00, "R10 status", status, 0);

    // vector table
    for (int v = 0; v < NV; v++) begin
      trigType = VECS[v].typ; srcSel = VECS[v].sel;
      lowLevel = VECS[v].lo; highLevel = VECS[v].hi;
      lowTime = VECS[v].loT; highTime = VECS[v].hiT;
      armWrite(1'b1);
      first = 15; cnt = 0;
      for (int i = 0; i < 8; i++) begin
        feed(VECS[v].smp[i*8 +: 8], 1'b1, p);
        if (p) begin
          cnt++;
          if (first == 15) first = i;
        end
      end
      chk(first == int'(VECS[v].exp), tagFor(VECS[v].typ), first, VECS[v].exp);
      chk(cnt == ((VECS[v].exp == 4'd15) ? 0 : 1), "R8 one-shot count", cnt,
          (VECS[v].exp == 4'd15) ? 0 : 1);
      chk(status == ((VECS[v].exp == 4'd15) ? 2'b01 : 2'b10), "R9 status", status,
          (VECS[v].exp == 4'd15) ? 1 : 2);
    end

    // R8 stop: arm then disarm, then a firing sequence gives nothing
    trigType = 3'd2; srcSel = 3'd0; lowLevel = 8'h28; highLevel = 8'hC8;
    lowTime = 8'd2; highTime = 8'd2;
    armWrite(1'b1);
    chk(status == 2'b01, "R9 busy after arm", status, 1);
    armWrite(1'b0);
    chk(status == 2'b00, "R8 stopped status", status, 0);
    cnt = 0;
    for (int i = 0; i < 6; i++) begin
      feed((i < 2) ? 8'h0A : 8'hFA, 1'b1, p);
      if (p) cnt++;
    end
    chk(cnt == 0, "R8 no pulse after stop", cnt, 0);

    // R11: disabled samples neither count nor break runs
    armWrite(1'b1);
    cnt = 0;
    feed(8'h0A, 1'b1, p); if (p) cnt++;
    for (int i = 0; i < 3; i++) begin feed(8'hFA, 1'b0, p); if (p) cnt++; end
    feed(8'h0A, 1'b1, p); if (p) cnt++;
    feed(8'hFA, 1'b1, p); if (p) cnt++;
    chk(cnt == 0, "R11 no early pulse", cnt, 0);
    feed(8'hFA, 1'b1, p);
    chk(p == 1'b1, "R11 fire after gated gap", p, 1);

    // R7 external rising: pulse after third edge
    trigType = 3'd0;
    armWrite(1'b1);
    extIn = 1'b1;
    cnt = 0;
    for (int i = 0; i < 2; i++) begin @(posedge clk); @(negedge clk); if (trigPulse) cnt++; end
    chk(cnt == 0, "R7 no pulse before sync", cnt, 0);
    @(posedge clk); @(negedge clk);
    chk(trigPulse == 1'b1, "R7 rising edge pulse", trigPulse, 1);
    @(posedge clk); @(negedge clk);
    chk(trigPulse == 1'b0, "R2 pulse one cycle", trigPulse, 0);

    // R7 external falling after re-arm
    trigType = 3'd1;
    armWrite(1'b1);
    extIn = 1'b0;
    @(posedge clk); @(negedge clk);
    @(posedge clk); @(negedge clk);
    chk(trigPulse == 1'b0, "R7 falling not yet", trigPulse, 0);
    @(posedge clk); @(negedge clk);
    chk(trigPulse == 1'b1, "R7 falling edge pulse", trigPulse, 1);
    chk(status == 2'b10, "R9 recording after ext", status, 2);
    armWrite(1'b1);
    chk(status == 2'b01, "R9 arm clears recording", status, 1);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule